// File: doc/BRIEF.md
# Sequential Restoring Unsigned Divider

This block divides an N-bit unsigned dividend by an N-bit unsigned divisor. It produces one quotient bit per clock. The method is restoring division. On each step the partial remainder and the dividend bits are shifted left together, and the divisor is subtracted as a trial. If the trial result is negative, the old partial remainder is kept and the quotient bit is 0. If it is not negative, the difference is kept and the quotient bit is 1. The partial remainder register is one bit wider than the operands, so the sign of the trial result can be seen directly.

A caller pulses `start_i` while the block is idle, together with the operands. It then waits for the one-cycle `done_o` pulse and reads `quotient_o` and `remainder_o`. Those outputs hold their values until the next accepted start. A zero divisor does not run any steps. The block finishes on the next cycle, raises `div_zero_o`, and returns fixed values.

Top module: `seq_udiv`

## Requirements
- R1: While `rst_ni` is low, `busy_o`, `done_o`, `div_zero_o`, `quotient_o` and `remainder_o` are all zero.
- R2: A start sampled while idle with a nonzero divisor raises `busy_o` on the next cycle. `done_o` rises exactly N clock edges after the sampling edge, in the same cycle that `busy_o` falls. `busy_o` and `done_o` are never high together.
- R3: `done_o` is high for a single cycle unless another start is sampled in that cycle.
- R4: For a nonzero divisor, `quotient_o` equals floor(dividend/divisor) and `remainder_o` equals dividend mod divisor. For example, with N=4, 7 divided by 3 gives 0010 and 0001.
- R5: When a nonzero division finishes, `remainder_o` is smaller than the divisor.
- R6: A start with a divisor of zero gives `done_o` and `div_zero_o` on the next cycle, with `busy_o` low. `quotient_o` is then all ones and `remainder_o` equals the dividend.
- R7: A start pulse while `busy_o` is high is ignored. The running division finishes at its original time with its original result, and no extra `done_o` follows.
- R8: While idle, `quotient_o`, `remainder_o` and `div_zero_o` keep their last values until a start is sampled. An accepted start with a nonzero divisor clears `div_zero_o`.
- R9: Boundary operands divide correctly: a dividend smaller than the divisor gives quotient 0 and remainder equal to the dividend, a divisor of 1 gives the dividend as quotient, and equal operands give quotient 1 and remainder 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled only while idle |
| dividend_i | input | N | Unsigned dividend |
| divisor_i | input | N | Unsigned divisor |
| busy_o | output | 1 | Division steps in progress |
| done_o | output | 1 | One-cycle completion pulse |
| div_zero_o | output | 1 | Last accepted division had a zero divisor |
| quotient_o | output | N | Quotient, valid from `done_o` until next start |
| remainder_o | output | N | Remainder, valid from `done_o` until next start |

## Verification
Several properties are checked on every cycle:
- `busy_o` and `done_o` are never high together.
- The latency, counted from the accepting edge, is exactly N.
- `done_o` is a single pulse.
- On completion, the remainder is smaller than the stored divisor.
- The zero-divisor response is correct.
- The stored divisor is untouched while busy.
- The outputs are stable while idle.

The arithmetic itself, floor quotient and modulo remainder, can only be shown by the bench's scenarios. These are an exhaustive sweep of every operand pair at N=4, including the zero-divisor and boundary pairs, and a start pulse injected mid-division whose effect is observed through the returned result and the count of completions.

// File: rtl/udiv_pkg.sv
package udiv_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } udiv_state_e;
endpackage

// File: rtl/udiv_step.sv
// One restoring iteration: shift {a,q} left, trial subtract, keep or restore.
module udiv_step #(
  parameter int N = 4
) (
  input  logic [N:0]   a_i,
  input  logic [N-1:0] q_i,
  input  logic [N-1:0] m_i,
  output logic [N:0]   a_o,
  output logic [N-1:0] q_o
);
  localparam int AQW = 2 * N + 1;

  logic [AQW-1:0] aq_sh;
  logic [N:0]     a_sh;
  logic [N:0]     trial;
  logic           neg;

  always_comb begin
    aq_sh = {a_i, q_i} << 1;
    a_sh  = aq_sh[AQW-1:N];
    trial = a_sh - {1'b0, m_i};
    neg   = trial[N];
    a_o   = neg ? a_sh : trial;
    q_o   = aq_sh[N-1:0] | {{(N-1){1'b0}}, ~neg};
  end
endmodule

// File: rtl/udiv_ctrl.sv
module udiv_ctrl #(
  parameter int N = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic zero_div_i,
  output logic load_o,
  output logic iter_o,
  output logic busy_o,
  output logic done_o,
  output logic div_zero_o
);
  import udiv_pkg::*;

  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(N - 1);

  udiv_state_e    state_q;
  logic [CW-1:0]  cnt_q;
  logic           done_q;
  logic           dz_q;
  logic           last_iter;

  assign load_o    = start_i && (state_q == ST_IDLE);
  assign iter_o    = (state_q == ST_RUN);
  assign last_iter = iter_o && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      dz_q    <= 1'b0;
    end else begin
      done_q <= last_iter || (load_o && zero_div_i);
      if (load_o) begin
        dz_q    <= zero_div_i;
        cnt_q   <= LAST_CNT;
        state_q <= zero_div_i ? ST_IDLE : ST_RUN;
      end else if (iter_o) begin
        cnt_q <= cnt_q - 1'b1;
        if (last_iter) state_q <= ST_IDLE;
      end
    end
  end

  assign busy_o     = iter_o;
  assign done_o     = done_q;
  assign div_zero_o = dz_q;
endmodule

// File: rtl/seq_udiv.sv
module seq_udiv #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [N-1:0] dividend_i,
  input  logic [N-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         div_zero_o,
  output logic [N-1:0] quotient_o,
  output logic [N-1:0] remainder_o
);
  logic [N:0]   a_q, a_nxt;
  logic [N-1:0] q_q, q_nxt;
  logic [N-1:0] m_q;
  logic         load, iter, zero_div;

  assign zero_div = (divisor_i == '0);

  udiv_ctrl #(.N(N)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .zero_div_i (zero_div),
    .load_o     (load),
    .iter_o     (iter),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .div_zero_o (div_zero_o)
  );

  udiv_step #(.N(N)) i_step (
    .a_i (a_q),
    .q_i (q_q),
    .m_i (m_q),
    .a_o (a_nxt),
    .q_o (q_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      q_q <= '0;
      m_q <= '0;
    end else if (load) begin
      m_q <= divisor_i;
      if (zero_div) begin
        a_q <= {1'b0, dividend_i};
        q_q <= '1;
      end else begin
        a_q <= '0;
        q_q <= dividend_i;
      end
    end else if (iter) begin
      a_q <= a_nxt;
      q_q <= q_nxt;
    end
  end

  assign quotient_o  = q_q;
  assign remainder_o = a_q[N-1:0];
endmodule

// File: rtl/udiv_chk.sv
module udiv_chk #(
  parameter int N = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [N-1:0] dividend_i,
  input logic [N-1:0] divisor_i,
  input logic         busy_o,
  input logic         done_o,
  input logic         div_zero_o,
  input logic [N-1:0] quotient_o,
  input logic [N-1:0] remainder_o,
  input logic [N-1:0] m_q
);
  localparam int LW = $clog2(N + 2) + 1;

  logic [LW-1:0] lat_cnt;
  logic          accept;

  assign accept = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lat_cnt <= '0;
    else if (accept) lat_cnt <= '0;
    else if (busy_o) lat_cnt <= lat_cnt + 1'b1;
  end

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o)); // R2
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && divisor_i != '0) |=> busy_o); // R2
  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !div_zero_o) |-> (lat_cnt == LW'(N))); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !done_o); // R3
  AST_REM_LT_DIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !div_zero_o) |-> (remainder_o < m_q)); // R5
  AST_ZERO_DIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && divisor_i == '0) |=> (done_o && div_zero_o && !busy_o &&
      quotient_o == '1 && remainder_o == $past(dividend_i))); // R6
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(m_q)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(quotient_o) && $stable(remainder_o) &&
      $stable(div_zero_o))); // R8
endmodule

bind seq_udiv udiv_chk #(.N(N)) i_chk (.*);

// File: tb/test_seq_udiv.sv
`timescale 1ns/1ps
module test_seq_udiv;
  localparam int N = 4;
  localparam int MAXV = 1 << N;

  typedef struct {
    logic [N-1:0] q;
    logic [N-1:0] r;
    logic [N-1:0] b;
    logic         dz;
    int           t0;
    int           lat;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [N-1:0] dvd = '0;
  logic [N-1:0] dvs = '0;
  logic         busy, done, dz;
  logic [N-1:0] quo, rem;

  int   cyc = 0;
  int   vectors = 0;
  int   miscompares = 0;
  exp_t scb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  seq_udiv #(.N(N)) i_seq_udiv (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .dividend_i  (dvd),
    .divisor_i   (dvs),
    .busy_o      (busy),
    .done_o      (done),
    .div_zero_o  (dz),
    .quotient_o  (quo),
    .remainder_o (rem)
  );

  task automatic do_div(input logic [N-1:0] a, input logic [N-1:0] b);
    exp_t e;
    while (busy) @(negedge clk);
    e.b   = b;
    e.t0  = cyc + 1;
    if (b == '0) begin
      e.q = '1; e.r = a; e.dz = 1'b1; e.lat = 0;
    end else begin
      e.q = a / b; e.r = a % b; e.dz = 1'b0; e.lat = N;
    end
    scb.push_back(e);
    start = 1'b1; dvd = a; dvs = b;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Monitor: pop on every done and compare.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        vectors++;
        if (scb.size() == 0) begin
          miscompares++;
          $display("FAIL R7 unexpected done: actual q=%0d r=%0d, expected no completion", quo, rem);
        end else begin
          exp_t e;
          e = scb.pop_front();
          if (busy) begin
            miscompares++;
            $display("FAIL R2 busy with done: actual 1 expected 0");
          end else if (cyc - e.t0 != e.lat) begin
            miscompares++;
            $display("FAIL R2 latency: actual %0d expected %0d", cyc - e.t0, e.lat);
          end else if (dz !== e.dz) begin
            miscompares++;
            $display("FAIL R6 R8 div_zero: actual %0b expected %0b", dz, e.dz);
          end else if (quo !== e.q || rem !== e.r) begin
            miscompares++;
            $display("FAIL R4 R6 R9 result: actual q=%0d r=%0d expected q=%0d r=%0d",
                     quo, rem, e.q, e.r);
          end else if (!e.dz && !(rem < e.b)) begin
            miscompares++;
            $display("FAIL R5 remainder: actual %0d expected below %0d", rem, e.b);
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string msg);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s", msg);
    end
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !dz && quo == '0 && rem == '0,
        $sformatf("R1 reset outputs: actual busy=%0b done=%0b dz=%0b q=%0d r=%0d expected all 0",
                  busy, done, dz, quo, rem));
    rst_n = 1'b1;
    @(negedge clk);

    // R4 worked example 7/3 -> 0010, 0001
    do_div(4'd7, 4'd3);
    // R9 boundaries and R6 zero divisor, then exhaustive sweep
    do_div(4'd2, 4'd9);
    do_div(4'd13, 4'd1);
    do_div(4'd15, 4'd15);
    do_div(4'd11, 4'd0);
    do_div(4'd5, 4'd0);
    do_div(4'd6, 4'd4);
    for (int a = 0; a < MAXV; a++)
      for (int b = 0; b < MAXV; b++)
        do_div(N'(a), N'(b));

    // R7: start pulse in the middle of a running division
    do_div(4'd13, 4'd2);
    @(negedge clk);
    chk(busy, $sformatf("R7 busy before stray start: actual %0b expected 1", busy));
    start = 1'b1; dvd = 4'd9; dvs = 4'd0;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);

    // R3 and R8: idle after completion, outputs held
    for (int k = 0; k < 4; k++) begin
      chk(!done, $sformatf("R3 done pulse width: actual done=%0b expected 0", done));
      chk(quo == 4'd6 && rem == 4'd1 && !dz && !busy,
          $sformatf("R8 R7 hold: actual q=%0d r=%0d dz=%0b expected q=6 r=1 dz=0", quo, rem, dz));
      @(negedge clk);
    end

    chk(scb.size() == 0,
        $sformatf("R2 pending results: actual %0d expected 0", scb.size()));
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule